// File: doc/BRIEF.md
# Dual-Mode Counter/PWM Timer

This block is a memory-mapped timer with a 32-bit up-counter. A functional clock advances the counter, either on every cycle or through a power-of-two prescaler. When the counter passes its all-ones value, it either reloads from a load register or stops after a single pass. A compare register can raise a match event. The overflow and match events set sticky interrupt status bits. Each status bit is cleared by writing a one to it. The status bits drive an interrupt line through an enable mask and a wakeup line through a separate wakeup mask.

An event output pin reports the counter's events. A two-bit trigger-mode field chooses which events reach the pin. A pulse-or-toggle bit chooses whether each event gives a one-cycle pulse or flips the pin. A default-level bit sets the pin's idle polarity.

Software reaches the block through a simple synchronous register bus. A write to any register except status, the interrupt enables, wakeup and interface control is accepted only when no earlier write to the same register is still in flight. A magic value written to the interface-control register starts a soft reset. A status register reports when that reset has finished.

Top module: `pwm_event_timer`

Register offsets (byte addresses): 0x00 control, 0x04 counter, 0x08 load, 0x0C match, 0x10 reload-trigger, 0x14 interrupt status, 0x18 enable-set (reads back the enable mask), 0x1C enable-clear, 0x20 wakeup mask, 0x24 interface control, 0x28 reset-done status, 0x2C write-pending flags.

Control bits: 0 start, 1 auto-reload, 4:2 prescale ratio, 5 prescale enable, 6 compare enable, 7 default pin level, 11:10 trigger mode, 12 toggle select.

## Requirements
- R1: The counter advances only while control bit 0 (start) is set. Writing the control register again with start already set neither restarts nor disturbs the count.
- R2: When control bit 5 is set, the counter advances once every 2^(ratio+1) cycles, where ratio is control bits 4:2. When bit 5 is clear, the counter advances every cycle.
- R3: A match event occurs when an advance brings the counter to the match-register value. It occurs only if control bit 6 is set, and it sets status bit 0.
- R4: An advance from all-ones is an overflow and sets status bit 1. With control bit 1 set, the counter takes the load value. With bit 1 clear, the counter becomes zero and hardware clears the start bit.
- R5: A write of any data to offset 0x10 copies the load register into the counter.
- R6: Trigger mode (control bits 11:10) selects the pin events: 00 gives none, so the pin sits at the default level; 01 gives overflow; 10 or 11 gives overflow and match.
- R7: With control bit 12 clear, each pin event is a one-cycle inversion of the default level (control bit 7). With bit 12 set, each event flips the pin.
- R8: Writing 1 to a status bit clears it. An event in the same cycle as the clear wins. The interrupt output is high when any status bit is set together with its enable bit.
- R9: Writing to offset 0x18 sets enable bits. Writing to offset 0x1C clears the same bits in both the enable mask and the wakeup mask (offset 0x20). The wakeup output is high when any status bit is set together with its wakeup bit.
- R10: Writing exactly 0x06 to offset 0x24 returns every register to zero and stops the counter. Offset 0x28 bit 0 reads 0 until the reset finishes and 1 afterwards. Any other value written there has no effect.
- R11: After an accepted write to control, counter, load, match or trigger, that register's pending flag at offset 0x2C is set for two cycles: bit 0 control, 1 counter, 2 load, 3 match, 4 trigger. A write to a register whose flag is set is ignored.
- R12: A write to offset 0x04 sets the counter value and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid on the following cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |
| pwm_out | output | 1 | Event/PWM output pin |

## Verification
A counter event and a software write-one-to-clear of the status bit can land on the same clock edge. The bench provokes this with a four-cycle auto-reload period: it counts the cycles from start so that the clear write hits exactly the edge where the counter overflows. It then judges the result by reading the status bit back, which must still be set, and by a later plain clear, which must leave it zero. A second collision, a counter write against a reload trigger and counting, is covered by the priority rule and checked through counter reads.

// File: rtl/pet_pkg.sv
package pet_pkg;
  localparam int BUS_W = 32;
  localparam int REG_AW = 6;
  localparam int NSTAT = 2;
  localparam int NPEND = 5;

  localparam logic [REG_AW-1:0] A_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] A_CNT   = 6'h04;
  localparam logic [REG_AW-1:0] A_LOAD  = 6'h08;
  localparam logic [REG_AW-1:0] A_MATCH = 6'h0C;
  localparam logic [REG_AW-1:0] A_TRIG  = 6'h10;
  localparam logic [REG_AW-1:0] A_STAT  = 6'h14;
  localparam logic [REG_AW-1:0] A_ENSET = 6'h18;
  localparam logic [REG_AW-1:0] A_ENCLR = 6'h1C;
  localparam logic [REG_AW-1:0] A_WAKE  = 6'h20;
  localparam logic [REG_AW-1:0] A_IFC   = 6'h24;
  localparam logic [REG_AW-1:0] A_SYS   = 6'h28;
  localparam logic [REG_AW-1:0] A_PEND  = 6'h2C;

  localparam logic [BUS_W-1:0] SRST_KEY  = 32'h0000_0006;
  localparam logic [BUS_W-1:0] CTRL_MASK = 32'h0000_1CFF;
  localparam logic [1:0]       PEND_HOLD = 2'd2;

  // pending slot order
  localparam int PI_CTRL = 0;
  localparam int PI_CNT = 1;
  localparam int PI_LOAD = 2;
  localparam int PI_MATCH = 3;
  localparam int PI_TRIG = 4;

  typedef struct packed {
    logic [18:0] rsvd_hi;
    logic        toggle;
    logic [1:0]  trig_mode;
    logic [1:0]  rsvd_mid;
    logic        dflt_lvl;
    logic        cmp_en;
    logic        pre_en;
    logic [2:0]  ratio;
    logic        reload;
    logic        start;
  } ctrl_t;

  function automatic logic [REG_AW-1:0] pend_addr(input int idx);
    case (idx)
      PI_CTRL:  pend_addr = A_CTRL;
      PI_CNT:   pend_addr = A_CNT;
      PI_LOAD:  pend_addr = A_LOAD;
      PI_MATCH: pend_addr = A_MATCH;
      default:  pend_addr = A_TRIG;
    endcase
  endfunction
endpackage

// File: rtl/pet_regs.sv
module pet_regs
  import pet_pkg::*;
#(
  parameter int RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output logic              ctrl_wr,
  output logic [BUS_W-1:0]  load_val,
  output logic [BUS_W-1:0]  match_val,
  output logic              cnt_wr,
  output logic              trig_wr,
  output logic              busy,
  output logic [NSTAT-1:0]  stat,
  output logic [NSTAT-1:0]  en,
  output logic              irq,
  output logic              wake,
  input  logic [BUS_W-1:0]  cnt_val,
  input  logic              ovf_evt,
  input  logic              match_evt,
  input  logic              oneshot_done
);
  localparam int BW = $clog2(RST_CYC + 1);

  logic [BW-1:0]    busy_q;
  logic [NPEND-1:0] pend, acc;
  logic             wr_ok, srst_req;
  logic [NSTAT-1:0] wake_q, clr_mask, set_mask, enclr_mask;
  ctrl_t            ctrl_q;
  logic [BUS_W-1:0] load_q, match_q;
  logic [NSTAT-1:0] stat_q, en_q;

  assign busy     = busy_q != '0;
  assign wr_ok    = wr && !busy;
  assign srst_req = wr_ok && (addr == A_IFC) && (wdata == SRST_KEY);

  for (genvar i = 0; i < NPEND; i++) begin : g_pend
    logic [1:0] pc_q;
    assign pend[i] = pc_q != 2'd0;
    assign acc[i]  = wr_ok && (addr == pend_addr(i)) && !pend[i];
    always_ff @(posedge clk) begin
      if (rst || busy)   pc_q <= 2'd0;
      else if (acc[i])   pc_q <= PEND_HOLD;
      else if (pend[i])  pc_q <= pc_q - 2'd1;
    end
  end

  assign ctrl_wr = acc[PI_CTRL];
  assign cnt_wr  = acc[PI_CNT];
  assign trig_wr = acc[PI_TRIG];

  assign clr_mask   = (wr_ok && addr == A_STAT)  ? wdata[NSTAT-1:0] : '0;
  assign set_mask   = (wr_ok && addr == A_ENSET) ? wdata[NSTAT-1:0] : '0;
  assign enclr_mask = (wr_ok && addr == A_ENCLR) ? wdata[NSTAT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)           busy_q <= '0;
    else if (srst_req) busy_q <= BW'(RST_CYC);
    else if (busy)     busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || busy) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      stat_q  <= '0;
      en_q    <= '0;
      wake_q  <= '0;
    end else begin
      if (acc[PI_CTRL])     ctrl_q <= ctrl_t'(wdata & CTRL_MASK);
      else if (oneshot_done) ctrl_q.start <= 1'b0;
      if (acc[PI_LOAD])  load_q  <= wdata;
      if (acc[PI_MATCH]) match_q <= wdata;
      stat_q <= (stat_q & ~clr_mask) | {ovf_evt, match_evt};
      en_q   <= (en_q | set_mask) & ~enclr_mask;
      if (wr_ok && addr == A_WAKE) wake_q <= wdata[NSTAT-1:0] & ~enclr_mask;
      else                         wake_q <= wake_q & ~enclr_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq  <= |(stat_q & en_q);
      wake <= |(stat_q & wake_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) begin
      case (addr)
        A_CTRL:  rdata <= ctrl_q;
        A_CNT:   rdata <= cnt_val;
        A_LOAD:  rdata <= load_q;
        A_MATCH: rdata <= match_q;
        A_STAT:  rdata <= {{(BUS_W-NSTAT){1'b0}}, stat_q};
        A_ENSET: rdata <= {{(BUS_W-NSTAT){1'b0}}, en_q};
        A_WAKE:  rdata <= {{(BUS_W-NSTAT){1'b0}}, wake_q};
        A_SYS:   rdata <= {{(BUS_W-1){1'b0}}, !busy};
        A_PEND:  rdata <= {{(BUS_W-NPEND){1'b0}}, pend};
        default: rdata <= '0;
      endcase
    end
  end

  assign ctrl      = ctrl_q;
  assign load_val  = load_q;
  assign match_val = match_q;
  assign stat      = stat_q;
  assign en        = en_q;
endmodule

// File: rtl/pet_prescale.sv
module pet_prescale #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic          en,
  input  logic [RW-1:0] ratio,
  output logic          tick
);
  localparam int DIVW = 2 ** RW;

  logic [DIVW-1:0] div_q, lim;
  logic            wrap;

  // limit = 2^(ratio+1) - 1
  assign lim  = {DIVW{1'b1}} >> (DIVW - 1 - int'(ratio));
  assign wrap = div_q == lim;
  assign tick = run && (!en || wrap);

  always_ff @(posedge clk) begin
    if (rst || clr || !run || !en) div_q <= '0;
    else if (wrap)                 div_q <= '0;
    else                           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pet_count.sv
module pet_count
  import pet_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  ctrl_t            ctrl,
  input  logic [BUS_W-1:0] load_val,
  input  logic [BUS_W-1:0] match_val,
  input  logic             cnt_wr,
  input  logic [BUS_W-1:0] cnt_wdata,
  input  logic             trig_wr,
  output logic [BUS_W-1:0] count,
  output logic             ovf_evt,
  output logic             match_evt,
  output logic             oneshot_done
);
  logic             tick, quiet, at_top;
  logic [BUS_W-1:0] cnt_q, nxt;

  pet_prescale #(.RW(RW)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .run   (ctrl.start),
    .en    (ctrl.pre_en),
    .ratio (ctrl.ratio[RW-1:0]),
    .tick  (tick)
  );

  assign quiet        = !cnt_wr && !trig_wr;
  assign at_top       = cnt_q == {BUS_W{1'b1}};
  assign nxt          = at_top ? (ctrl.reload ? load_val : '0) : cnt_q + 1'b1;
  assign ovf_evt      = tick && quiet && at_top;
  assign match_evt    = tick && quiet && ctrl.cmp_en && (nxt == match_val);
  assign oneshot_done = ovf_evt && !ctrl.reload;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= cnt_wdata;
    else if (trig_wr) cnt_q <= load_val;
    else if (tick)    cnt_q <= nxt;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pet_pin.sv
module pet_pin (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [1:0] mode,
  input  logic       toggle,
  input  logic       dflt,
  input  logic       ovf_evt,
  input  logic       match_evt,
  output logic       pin
);
  logic evt, tog_q;

  assign evt = (mode != 2'b00) && (ovf_evt || (mode[1] && match_evt));

  always_ff @(posedge clk) begin
    if (rst || clr || mode == 2'b00 || !toggle) tog_q <= 1'b0;
    else                                        tog_q <= tog_q ^ evt;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= dflt ^ (toggle ? (tog_q ^ evt) : evt);
  end
endmodule

// File: rtl/pwm_event_timer.sv
module pwm_event_timer
  import pet_pkg::*;
#(
  parameter int RST_CYC = 8,
  parameter int PRE_RW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              wake,
  output logic              pwm_out
);
  ctrl_t            ctrl;
  logic             ctrl_wr, cnt_wr, trig_wr, busy;
  logic             ovf_evt, match_evt, oneshot_done;
  logic [BUS_W-1:0] load_val, match_val, count;
  logic [NSTAT-1:0] stat, en;

  pet_regs #(.RST_CYC(RST_CYC)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr           (bus_wr),
    .rd           (bus_rd),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .rdata        (bus_rdata),
    .ctrl         (ctrl),
    .ctrl_wr      (ctrl_wr),
    .load_val     (load_val),
    .match_val    (match_val),
    .cnt_wr       (cnt_wr),
    .trig_wr      (trig_wr),
    .busy         (busy),
    .stat         (stat),
    .en           (en),
    .irq          (irq),
    .wake         (wake),
    .cnt_val      (count),
    .ovf_evt      (ovf_evt),
    .match_evt    (match_evt),
    .oneshot_done (oneshot_done)
  );

  pet_count #(.RW(PRE_RW)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .clr          (busy),
    .ctrl         (ctrl),
    .load_val     (load_val),
    .match_val    (match_val),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (bus_wdata),
    .trig_wr      (trig_wr),
    .count        (count),
    .ovf_evt      (ovf_evt),
    .match_evt    (match_evt),
    .oneshot_done (oneshot_done)
  );

  pet_pin u_pin (
    .clk       (clk),
    .rst       (rst),
    .clr       (busy),
    .mode      (ctrl.trig_mode),
    .toggle    (ctrl.toggle),
    .dflt      (ctrl.dflt_lvl),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt),
    .pin       (pwm_out)
  );
endmodule

// File: rtl/pet_checker.sv
module pet_checker
  import pet_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input ctrl_t            ctrl,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic             trig_wr,
  input logic             busy,
  input logic [BUS_W-1:0] count,
  input logic [BUS_W-1:0] load_val,
  input logic             ovf_evt,
  input logic [NSTAT-1:0] stat,
  input logic [NSTAT-1:0] en,
  input logic             irq,
  input logic             pwm_out
);
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.start && !cnt_wr && !trig_wr && !busy) |=> $stable(count));

  p_auto_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && ctrl.reload && !busy) |=> count == $past(load_val));

  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !ctrl.reload && !ctrl_wr) |=> !ctrl.start);

  p_trig_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && !cnt_wr) |=> count == $past(load_val));

  p_ovf_status_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !busy) |=> stat[1]);

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (|(stat & en)) |=> irq);

  p_idle_pin_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.trig_mode == 2'b00) |=> pwm_out == $past(ctrl.dflt_lvl));

  p_srst_clear_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (ctrl == '0) && (count == '0));
endmodule

bind pwm_event_timer pet_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrl     (ctrl),
  .ctrl_wr  (ctrl_wr),
  .cnt_wr   (cnt_wr),
  .trig_wr  (trig_wr),
  .busy     (busy),
  .count    (count),
  .load_val (load_val),
  .ovf_evt  (ovf_evt),
  .stat     (stat),
  .en       (en),
  .irq      (irq),
  .pwm_out  (pwm_out)
);

// File: tb/pwm_event_timer_tb_top.sv
module pwm_event_timer_tb_top;
  import pet_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [REG_AW-1:0] bus_addr = '0;
  logic [BUS_W-1:0]  bus_wdata = '0;
  logic [BUS_W-1:0]  bus_rdata;
  logic              irq, wake, pwm_out;

  always #10 clk = ~clk;

  pwm_event_timer dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .wake      (wake),
    .pwm_out   (pwm_out)
  );

  typedef struct {
    logic [BUS_W-1:0] exp;
    string            tag;
  } item_t;

  item_t sb_q[$];
  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic  rd_d = 1'b0;

  always @(posedge clk) rd_d <= bus_rd;

  task automatic check(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data is valid
  always @(negedge clk) begin
    if (rd_d) begin
      if (sb_q.size() == 0) check("scoreboard underrun", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  // all tasks enter and leave on a falling edge
  task automatic wr(input logic [REG_AW-1:0] a, input logic [BUS_W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [REG_AW-1:0] a, input logic [BUS_W-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start at edge E0, stop at E(m+1): m+1 counting edges
  task automatic run_for(input logic [BUS_W-1:0] c, input int m);
    wr(A_CTRL, c);
    idle(m);
    wr(A_CTRL, 32'd0);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic count_flips(input int n, output int fl);
    logic prev;
    fl = 0;
    prev = pwm_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== prev) fl++;
      prev = pwm_out;
    end
  endtask

  task automatic pin_case(input logic [BUS_W-1:0] c, input bit flips, input int exp, input string tag);
    int v;
    wr(A_CTRL, c);
    idle(6);
    if (flips) count_flips(40, v);
    else       count_high(40, v);
    check(tag, v, exp);
    wr(A_CTRL, 32'd0);
    idle(2);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // reset state
    check("reset pin R7", {31'd0, pwm_out}, 32'd0);
    check("reset irq R8", {31'd0, irq}, 32'd0);
    rd_exp(A_CTRL, 32'd0, "reset ctrl R1");
    rd_exp(A_SYS, 32'd1, "reset done R10");

    // R12 counter write, R1 counting with no prescale
    wr(A_CNT, 32'd100);
    run_for(32'h1, 9);
    rd_exp(A_CNT, 32'd110, "count 10 edges R1 R12");

    // R1 rewriting start does not disturb
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h1);
    idle(3);
    wr(A_CTRL, 32'h1);
    idle(3);
    wr(A_CTRL, 32'd0);
    rd_exp(A_CNT, 32'd8, "start rewrite R1");

    // R2 prescale divide by 4 and by 2
    wr(A_CNT, 32'd0);
    run_for(32'h25, 19);
    rd_exp(A_CNT, 32'd5, "prescale ratio1 R2");
    idle(2);
    wr(A_CNT, 32'd0);
    run_for(32'h21, 19);
    rd_exp(A_CNT, 32'd10, "prescale ratio0 R2");

    // R5 trigger reload
    wr(A_LOAD, 32'h1234);
    wr(A_TRIG, 32'hDEAD);
    rd_exp(A_CNT, 32'h1234, "trigger reload R5");

    // R4 auto-reload
    wr(A_STAT, 32'h3);
    wr(A_LOAD, 32'hFFFF_FFF0);
    wr(A_CNT, 32'hFFFF_FFFE);
    run_for(32'h3, 4);
    rd_exp(A_CNT, 32'hFFFF_FFF3, "auto reload R4");
    rd_exp(A_STAT, 32'h2, "overflow status R4");

    // R4 one-shot
    wr(A_STAT, 32'h3);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1);
    idle(5);
    rd_exp(A_CTRL, 32'h0, "oneshot clears start R4");
    rd_exp(A_CNT, 32'h0, "oneshot wraps to zero R4");
    rd_exp(A_STAT, 32'h2, "oneshot overflow R4");

    // R3 compare enable
    wr(A_STAT, 32'h3);
    wr(A_CNT, 32'd0);
    wr(A_MATCH, 32'd3);
    run_for(32'h41, 5);
    rd_exp(A_STAT, 32'h1, "match with compare R3");
    wr(A_STAT, 32'h3);
    wr(A_CNT, 32'd0);
    run_for(32'h1, 5);
    rd_exp(A_STAT, 32'h0, "no match without compare R3");

    // R8 interrupt
    wr(A_ENSET, 32'h2);
    idle(2);
    check("irq low with no status R8", {31'd0, irq}, 32'd0);
    wr(A_CNT, 32'hFFFF_FFFF);
    run_for(32'h1, 2);
    idle(1);
    check("irq on overflow R8", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h2);
    idle(2);
    check("irq cleared R8", {31'd0, irq}, 32'd0);

    // R9 enable/wake masks
    wr(A_WAKE, 32'h3);
    wr(A_ENSET, 32'h1);
    wr(A_ENCLR, 32'h1);
    rd_exp(A_ENSET, 32'h2, "enable after clear R9");
    rd_exp(A_WAKE, 32'h2, "wake after clear R9");
    wr(A_CNT, 32'hFFFF_FFFF);
    run_for(32'h1, 2);
    idle(1);
    check("wake on overflow R9", {31'd0, wake}, 32'd1);
    wr(A_ENCLR, 32'h2);
    idle(2);
    check("wake masked off R9", {31'd0, wake}, 32'd0);

    // R8 set beats clear in the same cycle
    wr(A_STAT, 32'h3);
    wr(A_LOAD, 32'hFFFF_FFFC);
    wr(A_CNT, 32'hFFFF_FFFC);
    wr(A_CTRL, 32'h3);
    idle(3);
    wr(A_STAT, 32'h2);
    wr(A_CTRL, 32'h0);
    rd_exp(A_STAT, 32'h2, "set wins over clear R8");
    wr(A_STAT, 32'h2);
    rd_exp(A_STAT, 32'h0, "plain clear R8");

    // R6 R7 pin behaviour, period 4, match at FFFFFFFE
    wr(A_MATCH, 32'hFFFF_FFFE);
    pin_case(32'h0403, 1'b0, 10, "overflow pulses R6 R7");
    pin_case(32'h0843, 1'b0, 20, "overflow and match pulses R6");
    pin_case(32'h0443, 1'b0, 10, "mode01 ignores match R6");
    pin_case(32'h0483, 1'b0, 30, "default high pulses R7");
    pin_case(32'h0083, 1'b0, 40, "mode00 holds default R6");
    pin_case(32'h1403, 1'b1, 10, "toggle flips R7");

    // R11 write pending
    wr(A_MATCH, 32'd5);
    wr(A_MATCH, 32'd7);
    rd_exp(A_MATCH, 32'd5, "second write ignored R11");
    wr(A_LOAD, 32'd9);
    rd_exp(A_PEND, 32'h4, "load pending flag R11");
    idle(3);
    rd_exp(A_PEND, 32'h0, "pending expired R11");

    // R10 soft reset
    wr(A_LOAD, 32'h55);
    wr(A_IFC, 32'h5);
    rd_exp(A_LOAD, 32'h55, "non-key ifc write ignored R10");
    wr(A_IFC, SRST_KEY);
    rd_exp(A_SYS, 32'h0, "reset in progress R10");
    idle(10);
    rd_exp(A_SYS, 32'h1, "reset complete R10");
    rd_exp(A_LOAD, 32'h0, "load cleared R10");
    rd_exp(A_CTRL, 32'h0, "ctrl cleared R10");

    idle(3);
    if (sb_q.size() != 0) check("scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule